// File: doc/BRIEF.md
# Background Model Ping-Pong Memory Controller

This block sits between a per-pixel background-modelling pipeline and two external single-port SRAM banks. The banks hold the model parameters of every pixel in a frame: a central intensity and a weight for each cluster. The pipeline reads one pixel's parameters and writes back the updated set for an earlier pixel, both in the same clock cycle. A single-port bank cannot do both, so the controller gives one bank the read role and the other the write role for a whole frame. It then swaps the two roles once the frame's last update has been written.

The pipeline presents a pixel address with a valid strobe, plus a start-of-frame flag on the first pixel of each frame. Parameters come back one cycle later. The write-back address is not carried through the pipeline: the controller delays the read address by the pipeline depth. The updated data must appear on the write-back input exactly that many cycles after the read. Until the first swap, the banks hold nothing valid, so reads return a fixed starting model instead of bank contents.

Top module: `bg_model_pingpong`

## Requirements
- R1: While reset is held, `readBank` is 0 (bank A reads), neither bank is enabled, and `rdDataValid` is 0.
- R2: In a cycle with `rdValid` high, the read bank (A when `readBank`=0, B when 1) is enabled with write-enable low and its address equal to `rdAddr`.
- R3: One cycle after a cycle with `rdValid` high, `rdDataValid` is high and `rdData` carries the parameters of that address.
- R4: Until the first role swap, `rdData` is the starting model instead of bank data. Cluster k occupies bits [16k+15:16k], with its centre in the low byte and its weight in the high byte. The centres are 0, 128 and 255 for k = 0, 1, 2, and every weight is 10, so the value is 48'h0AFF_0A80_0A00.
- R5: PIPE_DEPTH cycles after a read, the bank opposite to `readBank` is enabled with write-enable high, the address of that read, and the value present on `wbData` in that cycle.
- R6: Writes are counted from the write that belongs to the read flagged with `sof`. On the clock edge that completes the FRAME_W*FRAME_H-th write of the frame, `readBank` inverts and the starting-model substitution of R4 ends. At every other edge `readBank` holds its value.
- R7: After a swap, a read of any address returns the value written to that address during the previous frame, regardless of the order in which that frame visited its addresses. One read per clock is sustained.
- R8: Within one frame, no bank is both read and written. In particular, an address is never read and written in the same bank within the same frame.
- R9: A cycle with `rdValid` low causes no bank access in that cycle, gives `rdDataValid` low in the next cycle, and produces no write PIPE_DEPTH cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sof | input | 1 | First pixel of a frame, qualified by rdValid |
| rdValid | input | 1 | Pipeline requests a parameter read |
| rdAddr | input | ADDR_W | Pixel address to read |
| wbData | input | DATA_W | Updated parameters for the read made PIPE_DEPTH cycles earlier |
| rdData | output | DATA_W | Parameters returned one cycle after the read |
| rdDataValid | output | 1 | rdData holds a returned read |
| readBank | output | 1 | Bank currently in the read role (0 = A, 1 = B) |
| bankAEn | output | 1 | Bank A access enable |
| bankAWe | output | 1 | Bank A write enable |
| bankAAddr | output | ADDR_W | Bank A address |
| bankAWdata | output | DATA_W | Bank A write data |
| bankARdata | input | DATA_W | Bank A read data, one cycle after the access |
| bankBEn | output | 1 | Bank B access enable |
| bankBWe | output | 1 | Bank B write enable |
| bankBAddr | output | ADDR_W | Bank B address |
| bankBWdata | output | DATA_W | Bank B write data |
| bankBRdata | input | DATA_W | Bank B read data, one cycle after the access |

## Verification
The hardest situation to reach is the frame boundary under full load. The last writes of one frame are still draining into a bank while the next frame is about to read from it. The role swap must land exactly between the final write and the first new read. The bench reaches this by running back-to-back frames separated by exactly PIPE_DEPTH idle cycles, which is the minimum gap. It also runs a frame with bubbles and a frame that visits addresses in reverse order, so the write count and the swap timing are checked apart from address order. The bench memories start filled with junk, so the starting model of the first frame can only appear through the substitution path.

// File: rtl/ppm_pkg.sv
package ppm_pkg;

  // Strobes from control to datapath, valid in the current cycle.
  typedef struct packed {
    logic rdEn;      // read access to the read bank this cycle
    logic wrEn;      // write-back slot to the write bank this cycle
    logic readBank;  // 0: bank A reads, bank B is written; 1: swapped
    logic useInit;   // no frame completed yet: substitute starting model
  } bankStrobe_t;

endpackage

// File: rtl/ppm_ctrl.sv
module ppm_ctrl #(
  parameter int FRAME_PIX  = 307200,
  parameter int PIPE_DEPTH = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sof,
  input  logic                  rdValid,
  output ppm_pkg::bankStrobe_t  strobe,
  output logic                  rdDataValid
);

  localparam int CNT_W = $clog2(FRAME_PIX + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_PIX - 1);

  logic [PIPE_DEPTH-1:0] validPipe;
  logic [PIPE_DEPTH-1:0] sofPipe;
  logic [CNT_W-1:0]      wrCount;
  logic [CNT_W-1:0]      wrIdx;
  logic                  readBank;
  logic                  firstFrame;
  logic                  wrSlot;
  logic                  lastWrite;

  // Stage 0 of the valid / start-of-frame delay line.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validPipe[0] <= 1'b0;
      sofPipe[0]   <= 1'b0;
    end else begin
      validPipe[0] <= rdValid;
      sofPipe[0]   <= sof && rdValid;
    end
  end

  // Remaining stages, one register per pipeline step.
  for (genvar s = 1; s < PIPE_DEPTH; s++) begin : g_dly
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validPipe[s] <= 1'b0;
        sofPipe[s]   <= 1'b0;
      end else begin
        validPipe[s] <= validPipe[s-1];
        sofPipe[s]   <= sofPipe[s-1];
      end
    end
  end

  assign wrSlot    = validPipe[PIPE_DEPTH-1];
  assign wrIdx     = sofPipe[PIPE_DEPTH-1] ? '0 : wrCount;
  assign lastWrite = wrSlot && (wrIdx == LAST_IDX);

  // Write counter and bank roles: swap only on the frame's final write.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrCount    <= '0;
      readBank   <= 1'b0;
      firstFrame <= 1'b1;
    end else begin
      if (wrSlot) begin
        wrCount <= lastWrite ? '0 : wrIdx + 1'b1;
      end
      if (lastWrite) begin
        readBank   <= ~readBank;
        firstFrame <= 1'b0;
      end
    end
  end

  always_comb begin
    strobe.rdEn     = rdValid;
    strobe.wrEn     = wrSlot;
    strobe.readBank = readBank;
    strobe.useInit  = firstFrame;
  end

  assign rdDataValid = validPipe[0];

endmodule

// File: rtl/ppm_datapath.sv
module ppm_datapath #(
  parameter int ADDR_W      = 19,
  parameter int CLUSTERS    = 3,
  parameter int CENTRE_W    = 8,
  parameter int WEIGHT_W    = 8,
  parameter int INIT_WEIGHT = 10,
  parameter int PIPE_DEPTH  = 5,
  localparam int SLOT_W     = CENTRE_W + WEIGHT_W,
  localparam int DATA_W     = CLUSTERS * SLOT_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ppm_pkg::bankStrobe_t strobe,
  input  logic [ADDR_W-1:0]    rdAddr,
  input  logic [DATA_W-1:0]    wbData,
  output logic [DATA_W-1:0]    rdData,
  output logic                 bankAEn,
  output logic                 bankAWe,
  output logic [ADDR_W-1:0]    bankAAddr,
  output logic [DATA_W-1:0]    bankAWdata,
  input  logic [DATA_W-1:0]    bankARdata,
  output logic                 bankBEn,
  output logic                 bankBWe,
  output logic [ADDR_W-1:0]    bankBAddr,
  output logic [DATA_W-1:0]    bankBWdata,
  input  logic [DATA_W-1:0]    bankBRdata
);

  localparam int CENTRE_MAX = (1 << CENTRE_W) - 1;

  logic [ADDR_W-1:0] addrPipe [PIPE_DEPTH];
  logic [ADDR_W-1:0] wrAddr;
  logic [DATA_W-1:0] initParams;
  logic              rdBankQ;
  logic              useInitQ;
  logic              aIsRead;
  logic              bIsRead;

  // Starting model: centres spread evenly over the intensity range.
  for (genvar k = 0; k < CLUSTERS; k++) begin : g_init
    localparam int RAW = (CLUSTERS > 1) ? ((1 << CENTRE_W) * k) / (CLUSTERS - 1) : 0;
    localparam int CEN = (RAW > CENTRE_MAX) ? CENTRE_MAX : RAW;
    assign initParams[k*SLOT_W +: SLOT_W] = {WEIGHT_W'(INIT_WEIGHT), CENTRE_W'(CEN)};
  end

  // Read address delayed by the pipeline depth becomes the write address.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) addrPipe[0] <= '0;
    else       addrPipe[0] <= rdAddr;
  end

  for (genvar s = 1; s < PIPE_DEPTH; s++) begin : g_adly
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) addrPipe[s] <= '0;
      else       addrPipe[s] <= addrPipe[s-1];
    end
  end

  assign wrAddr = addrPipe[PIPE_DEPTH-1];

  // Port steering by role.
  assign aIsRead = !strobe.readBank;
  assign bIsRead =  strobe.readBank;

  always_comb begin
    bankAEn    = aIsRead ? strobe.rdEn : strobe.wrEn;
    bankAWe    = !aIsRead && strobe.wrEn;
    bankAAddr  = aIsRead ? rdAddr : wrAddr;
    bankAWdata = wbData;
    bankBEn    = bIsRead ? strobe.rdEn : strobe.wrEn;
    bankBWe    = !bIsRead && strobe.wrEn;
    bankBAddr  = bIsRead ? rdAddr : wrAddr;
    bankBWdata = wbData;
  end

  // Remember the source of each read for the returning cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdBankQ  <= 1'b0;
      useInitQ <= 1'b1;
    end else if (strobe.rdEn) begin
      rdBankQ  <= strobe.readBank;
      useInitQ <= strobe.useInit;
    end
  end

  assign rdData = useInitQ ? initParams : (rdBankQ ? bankBRdata : bankARdata);

endmodule

// File: rtl/bg_model_pingpong.sv
module bg_model_pingpong #(
  parameter int FRAME_W     = 640,
  parameter int FRAME_H     = 480,
  parameter int PIPE_DEPTH  = 5,
  parameter int CLUSTERS    = 3,
  parameter int CENTRE_W    = 8,
  parameter int WEIGHT_W    = 8,
  parameter int INIT_WEIGHT = 10,
  localparam int FRAME_PIX  = FRAME_W * FRAME_H,
  localparam int ADDR_W     = $clog2(FRAME_PIX),
  localparam int DATA_W     = CLUSTERS * (CENTRE_W + WEIGHT_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sof,
  input  logic              rdValid,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] wbData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDataValid,
  output logic              readBank,
  output logic              bankAEn,
  output logic              bankAWe,
  output logic [ADDR_W-1:0] bankAAddr,
  output logic [DATA_W-1:0] bankAWdata,
  input  logic [DATA_W-1:0] bankARdata,
  output logic              bankBEn,
  output logic              bankBWe,
  output logic [ADDR_W-1:0] bankBAddr,
  output logic [DATA_W-1:0] bankBWdata,
  input  logic [DATA_W-1:0] bankBRdata
);

  ppm_pkg::bankStrobe_t strobe;

  ppm_ctrl #(
    .FRAME_PIX (FRAME_PIX),
    .PIPE_DEPTH(PIPE_DEPTH)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sof        (sof),
    .rdValid    (rdValid),
    .strobe     (strobe),
    .rdDataValid(rdDataValid)
  );

  ppm_datapath #(
    .ADDR_W     (ADDR_W),
    .CLUSTERS   (CLUSTERS),
    .CENTRE_W   (CENTRE_W),
    .WEIGHT_W   (WEIGHT_W),
    .INIT_WEIGHT(INIT_WEIGHT),
    .PIPE_DEPTH (PIPE_DEPTH)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .rdAddr    (rdAddr),
    .wbData    (wbData),
    .rdData    (rdData),
    .bankAEn   (bankAEn),
    .bankAWe   (bankAWe),
    .bankAAddr (bankAAddr),
    .bankAWdata(bankAWdata),
    .bankARdata(bankARdata),
    .bankBEn   (bankBEn),
    .bankBWe   (bankBWe),
    .bankBAddr (bankBAddr),
    .bankBWdata(bankBWdata),
    .bankBRdata(bankBRdata)
  );

  assign readBank = strobe.readBank;

endmodule

// File: rtl/bg_model_pingpong_chk.sv
module bg_model_pingpong_chk #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdValid,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              rdDataValid,
  input logic              readBank,
  input logic              bankAEn,
  input logic              bankAWe,
  input logic [ADDR_W-1:0] bankAAddr,
  input logic              bankBEn,
  input logic              bankBWe,
  input logic [ADDR_W-1:0] bankBAddr
);

  // R2
  read_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (readBank ? (bankBEn && !bankBWe && bankBAddr == rdAddr)
                          : (bankAEn && !bankAWe && bankAAddr == rdAddr)));

  // R3
  read_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> rdDataValid);

  // R9
  idle_no_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |=> !rdDataValid);

  // R5
  write_a_side_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bankAEn && bankAWe) |-> readBank);

  // R5
  write_b_side_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bankBEn && bankBWe) |-> !readBank);

  // R8
  no_mixed_bank_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> !(readBank ? (bankBEn && bankBWe) : (bankAEn && bankAWe)));

  // R6
  swap_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(readBank) |-> $past((bankAEn && bankAWe) || (bankBEn && bankBWe)));

endmodule

bind bg_model_pingpong bg_model_pingpong_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .rdValid    (rdValid),
  .rdAddr     (rdAddr),
  .rdDataValid(rdDataValid),
  .readBank   (readBank),
  .bankAEn    (bankAEn),
  .bankAWe    (bankAWe),
  .bankAAddr  (bankAAddr),
  .bankBEn    (bankBEn),
  .bankBWe    (bankBWe),
  .bankBAddr  (bankBAddr)
);

// File: tb/bg_model_pingpong_bench.sv
module bg_model_pingpong_bench;

  localparam int FW = 8;
  localparam int FH = 4;
  localparam int FP = FW * FH;
  localparam int AW = 5;
  localparam int D  = 4;
  localparam int DW = 48;
  localparam logic [DW-1:0] INIT_MODEL = 48'h0AFF_0A80_0A00;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          sof = 1'b0;
  logic          rdValid = 1'b0;
  logic [AW-1:0] rdAddr = '0;
  logic [DW-1:0] wbData = '0;
  logic [DW-1:0] rdData;
  logic          rdDataValid;
  logic          readBank;
  logic          bankAEn, bankAWe, bankBEn, bankBWe;
  logic [AW-1:0] bankAAddr, bankBAddr;
  logic [DW-1:0] bankAWdata, bankBWdata;
  logic [DW-1:0] bankARdata = '0;
  logic [DW-1:0] bankBRdata = '0;

  logic [DW-1:0] memA [FP];
  logic [DW-1:0] memB [FP];

  int total = 0;
  int fails = 0;

  // Bench-side pipeline history and expectation state.
  logic histV [D+1];
  int   histA [D+1];
  int   histF [D+1];
  int   rdTag [2][FP];
  int   wrTag [2][FP];
  logic prevV = 1'b0;
  int   prevA = 0;
  int   prevF = 0;
  logic expBank = 1'b0;
  logic flipPending = 1'b0;
  int   wrCnt = 0;

  bg_model_pingpong #(
    .FRAME_W(FW), .FRAME_H(FH), .PIPE_DEPTH(D)
  ) u_bg_model_pingpong (
    .clk(clk), .rstN(rstN), .sof(sof), .rdValid(rdValid), .rdAddr(rdAddr),
    .wbData(wbData), .rdData(rdData), .rdDataValid(rdDataValid), .readBank(readBank),
    .bankAEn(bankAEn), .bankAWe(bankAWe), .bankAAddr(bankAAddr),
    .bankAWdata(bankAWdata), .bankARdata(bankARdata),
    .bankBEn(bankBEn), .bankBWe(bankBWe), .bankBAddr(bankBAddr),
    .bankBWdata(bankBWdata), .bankBRdata(bankBRdata)
  );

  always #10 clk = ~clk;

  // Single-port synchronous memories, one-cycle read.
  always @(posedge clk) begin
    if (bankAEn) begin
      if (bankAWe) memA[bankAAddr] <= bankAWdata;
      else         bankARdata <= memA[bankAAddr];
    end
    if (bankBEn) begin
      if (bankBWe) memB[bankBAddr] <= bankBWdata;
      else         bankBRdata <= memB[bankBAddr];
    end
  end

  function automatic logic [DW-1:0] upd(input int fr, input int a);
    return {8'(fr), 8'(a), 8'(fr * 3 + 1), 8'(a) ^ 8'h5A, 8'(fr + a), 8'hC3};
  endfunction

  function automatic logic [DW-1:0] expRead(input int fr, input int a);
    return (fr == 0) ? INIT_MODEL : upd(fr - 1, a);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock of stimulus plus all port checks for that clock.
  task automatic step(input logic v, input logic s, input int a, input int fr);
    logic          rbEn, rbWe, wbEn, wbWe;
    logic [AW-1:0] rbAddr, wbAddr;
    logic [DW-1:0] wbWd;
    @(negedge clk);
    if (flipPending) begin
      expBank = ~expBank;
      flipPending = 1'b0;
    end
    // R3 / R4 / R7 / R9: result of the previous cycle's read
    if (prevV) begin
      chk(rdDataValid == 1'b1, "R3", 64'(rdDataValid), 64'd1);
      chk(rdData == expRead(prevF, prevA), (prevF == 0) ? "R4" : "R7",
          64'(rdData), 64'(expRead(prevF, prevA)));
    end else begin
      chk(rdDataValid == 1'b0, "R9", 64'(rdDataValid), 64'd0);
    end
    rdValid = v;
    sof     = s;
    rdAddr  = AW'(a);
    for (int i = D; i > 0; i--) begin
      histV[i] = histV[i-1];
      histA[i] = histA[i-1];
      histF[i] = histF[i-1];
    end
    histV[0] = v;
    histA[0] = a;
    histF[0] = fr;
    wbData = upd(histF[D], histA[D]);
    #1;
    // R6: role held until the frame's last write edge
    chk(readBank == expBank, "R6", 64'(readBank), 64'(expBank));
    rbEn   = expBank ? bankBEn   : bankAEn;
    rbWe   = expBank ? bankBWe   : bankAWe;
    rbAddr = expBank ? bankBAddr : bankAAddr;
    wbEn   = expBank ? bankAEn   : bankBEn;
    wbWe   = expBank ? bankAWe   : bankBWe;
    wbAddr = expBank ? bankAAddr : bankBAddr;
    wbWd   = expBank ? bankAWdata : bankBWdata;
    if (v) begin
      chk(rbEn == 1'b1 && rbWe == 1'b0, "R2", {62'd0, rbEn, rbWe}, 64'h2);
      chk(rbAddr == AW'(a), "R2", 64'(rbAddr), 64'(a));
      chk(wrTag[expBank][a] != fr, "R8", 64'(wrTag[expBank][a]), 64'(fr));
      rdTag[expBank][a] = fr;
    end else begin
      chk(rbEn == 1'b0, "R9", 64'(rbEn), 64'd0);
    end
    chk(wbEn == histV[D], histV[D] ? "R5" : "R9", 64'(wbEn), 64'(histV[D]));
    if (histV[D]) begin
      chk(wbWe == 1'b1, "R5", 64'(wbWe), 64'd1);
      chk(wbAddr == AW'(histA[D]), "R5", 64'(wbAddr), 64'(histA[D]));
      chk(wbWd == upd(histF[D], histA[D]), "R5", 64'(wbWd), 64'(upd(histF[D], histA[D])));
      chk(rdTag[!expBank][histA[D]] != histF[D], "R8",
          64'(rdTag[!expBank][histA[D]]), 64'(histF[D]));
      wrTag[!expBank][histA[D]] = histF[D];
      wrCnt++;
      if (wrCnt == FP) begin
        wrCnt = 0;
        flipPending = 1'b1;
      end
    end
    prevV = v;
    prevA = a;
    prevF = fr;
  endtask

  task automatic runFrame(input int fr, input bit reverse, input bit bubbles);
    for (int i = 0; i < FP; i++) begin
      int a;
      a = reverse ? (FP - 1 - i) : i;
      if (bubbles && (i % 3 == 1)) begin
        step(1'b0, 1'b0, 0, fr);
        step(1'b0, 1'b0, 0, fr);
      end
      step(1'b1, i == 0, a, fr);
    end
    for (int g = 0; g < D; g++) step(1'b0, 1'b0, 0, fr);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    chk(readBank == 1'b0, "R1", 64'(readBank), 64'd0);
    chk(bankAEn == 1'b0 && bankBEn == 1'b0, "R1", {62'd0, bankAEn, bankBEn}, 64'd0);
    chk(rdDataValid == 1'b0, "R1", 64'(rdDataValid), 64'd0);
    rstN = 1'b1;
  endtask

  // R4: first frame sees only the starting model, memories hold junk
  task automatic testFirstFrame();
    runFrame(0, 1'b0, 1'b0);
  endtask

  // R6 / R7: next frame starts after the minimum drain gap
  task automatic testBackToBack();
    runFrame(1, 1'b0, 1'b0);
  endtask

  // R7: reverse visiting order, swap still by count
  task automatic testReverseOrder();
    runFrame(2, 1'b1, 1'b0);
  endtask

  // R9: idle cycles inside a frame
  task automatic testBubbles();
    runFrame(3, 1'b0, 1'b1);
  endtask

  // R7: read back what the bubbled frame wrote
  task automatic testFinalReadback();
    runFrame(4, 1'b0, 1'b0);
    for (int g = 0; g < 2; g++) step(1'b0, 1'b0, 0, 5);
    chk(readBank == 1'b1, "R6", 64'(readBank), 64'd1);
  endtask

  initial begin
    for (int i = 0; i < FP; i++) begin
      memA[i] = 48'hBAD0_0000_0000 | 48'(i);
      memB[i] = 48'hDEAD_0000_0000 | 48'(i);
      rdTag[0][i] = -1; rdTag[1][i] = -1;
      wrTag[0][i] = -1; wrTag[1][i] = -1;
    end
    for (int i = 0; i <= D; i++) begin
      histV[i] = 1'b0; histA[i] = 0; histF[i] = 0;
    end
    testReset();
    testFirstFrame();
    testBackToBack();
    testReverseOrder();
    testBubbles();
    testFinalReadback();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule